// File: doc/BRIEF.md
# Validation Test Coprocessor with Timers

This block is a test-support coprocessor that answers two coprocessor numbers (parameters, 4 and 5 by default). Both numbers share one bank of sixteen 32-bit registers. Register transfers to and from the processor work on either number. Memory word transfers of one or two words are accepted only on the first number. Data operations make the processor stall for a programmed number of cycles, schedule an active-low fast or normal interrupt line to fall after a programmed delay, release those lines, and capture the free-running cycle count into a register.

The processor presents one instruction per cycle. It gives the coprocessor number, the instruction class (register write, register read, memory load, memory store, data operation) and the instruction word, and marks the first cycle of each instruction. The coprocessor replies in the same cycle with absent, done, busy or undefined. The cycle count is an input, so the block follows whatever time base the system uses. All elapsed-time tests use the unsigned difference from a captured start value, so they stay correct when the count wraps.

Top module: `valtest_cop`

## Requirements
- R1: While reset is low, and after it, until an instruction changes them, `fiq_n` and `irq_n` are 1, no delayed interrupt is pending, and every register reads 0.
- R2: On either coprocessor number, class 0 (register write) stores `wr_data` into the register selected by word bits 19:16 at the clock edge. Class 1 (register read) drives that register on `rd_data` in the same cycle. Both answer done (rsp=1).
- R3: On the first number only, class 2 (load) writes `wr_data` into the register selected by bits 15:12, and class 3 (store) drives that register on `rd_data`. When bit 22 is set the transfer is long: the first cycle (`ins_first`=1) moves the word at that index and answers busy (rsp=2), and the next cycle (`ins_first`=0) moves the word at index+1 modulo 16 and answers done. When bit 22 is clear the transfer moves one word and answers done.
- R4: Class 4 (data operation) with opcode 0 in bits 23:20 on either number is a stall. On the first cycle the block captures the cycle count and reads the delay from the register selected by bits 3:0, answering busy if the delay is nonzero and done otherwise. On later cycles it answers busy while (count − start) < delay, and done otherwise.
- R5: On the second number, opcode 1 (fast line) and opcode 2 (normal line) answer done and schedule the line. At the issuing edge the count is recorded as the start and the register selected by bits 3:0 as the delay. The line goes to 0 at the first later edge where (count − start) ≥ delay, and stays 0 until it is released. Issuing again restarts the schedule.
- R6: On the second number, opcode 3 sets `fiq_n` to 1 and opcode 4 sets `irq_n` to 1 at the next edge. Each also cancels that line's pending schedule. A release takes precedence over an expiry in the same cycle.
- R7: On the second number, opcode 5 writes the current cycle count into the register selected by bits 3:0 and answers done.
- R8: The block answers undefined (rsp=3) and changes no state in these cases: a load or store on the second number, a data opcode above 5, a data opcode other than 0 on the first number, or an instruction class 5 to 7.
- R9: With `ins_valid` low, or with a coprocessor number other than the two served, rsp is 0 (absent), `rd_data` is 0 and no state changes.
- R10: Stall and interrupt delays behave as in R4 and R5 when the cycle count wraps from all ones to zero during the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_now | input | DATA_W | Free-running cycle count |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_first | input | 1 | First cycle of the presented instruction |
| ins_kind | input | 3 | Class: 0 reg write, 1 reg read, 2 load, 3 store, 4 data op |
| ins_cpnum | input | 4 | Coprocessor number of the instruction |
| ins_word | input | 32 | Instruction word |
| wr_data | input | DATA_W | Data from the processor (reg write, load) |
| rd_data | output | DATA_W | Data to the processor (reg read, store), else 0 |
| rsp | output | 2 | 0 absent, 1 done, 2 busy, 3 undefined |
| fiq_n | output | 1 | Active-low fast interrupt line |
| irq_n | output | 1 | Active-low normal interrupt line |

## Verification
A corrupted register shows on `rd_data` at the next read of that index. Through the delay operand it also shifts a stall end or an interrupt fall by a measurable number of cycles. A wrong start value or a lost pending flag shows as a line that falls one or more cycles early or late, or never falls. A wrong latched stall value shows as a busy/done reply on the wrong cycle. The reference model is compared with every output on every cycle, so any of these is seen in the cycle it first reaches a port.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

   typedef enum logic [1:0] {
      RSP_ABSENT = 2'd0,
      RSP_DONE   = 2'd1,
      RSP_BUSY   = 2'd2,
      RSP_UNDEF  = 2'd3
   } vtc_rsp_e;

   typedef enum logic [2:0] {
      KIND_REG_WR = 3'd0,
      KIND_REG_RD = 3'd1,
      KIND_MEM_LD = 3'd2,
      KIND_MEM_ST = 3'd3,
      KIND_DATAOP = 3'd4
   } vtc_kind_e;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_UNDEF,
      OP_WR,
      OP_RD,
      OP_LD,
      OP_ST,
      OP_STALL,
      OP_SCHED_F,
      OP_SCHED_I,
      OP_REL_F,
      OP_REL_I,
      OP_CAP
   } vtc_op_e;

endpackage

// File: rtl/vtc_decode.sv
module vtc_decode
   import vtc_pkg::*;
#(
   parameter int CP_A  = 4,
   parameter int CP_B  = 5,
   parameter int IDX_W = 4
)(
   input  logic             valid,
   input  logic [2:0]       kind,
   input  logic [3:0]       cpnum,
   input  logic [31:0]      word,
   output vtc_op_e          op,
   output logic [IDX_W-1:0] rn_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic [IDX_W-1:0] rm_idx,
   output logic             is_long
);
   localparam logic [3:0] CPA_L = 4'(CP_A);
   localparam logic [3:0] CPB_L = 4'(CP_B);

   logic [3:0] opc;
   logic       hit_a;
   logic       hit_b;
   logic       unused_bits;

   assign opc         = word[23:20];
   assign hit_a       = valid && (cpnum == CPA_L);
   assign hit_b       = valid && (cpnum == CPB_L);
   assign rn_idx      = word[16 +: IDX_W];
   assign rd_idx      = word[12 +: IDX_W];
   assign rm_idx      = word[0 +: IDX_W];
   assign is_long     = word[22];
   assign unused_bits = ^{word[31:24], word[11:4]};

   always_comb begin
      op = OP_NONE;
      if (hit_a || hit_b) begin
         unique case (kind)
            KIND_REG_WR: op = OP_WR;
            KIND_REG_RD: op = OP_RD;
            KIND_MEM_LD: op = hit_a ? OP_LD : OP_UNDEF;
            KIND_MEM_ST: op = hit_a ? OP_ST : OP_UNDEF;
            KIND_DATAOP: begin
               if (opc == 4'd0)      op = OP_STALL;
               else if (hit_a)       op = OP_UNDEF;
               else begin
                  unique case (opc)
                     4'd1:    op = OP_SCHED_F;
                     4'd2:    op = OP_SCHED_I;
                     4'd3:    op = OP_REL_F;
                     4'd4:    op = OP_REL_I;
                     4'd5:    op = OP_CAP;
                     default: op = OP_UNDEF;
                  endcase
               end
            end
            default: op = OP_UNDEF;
         endcase
      end
   end

endmodule

// File: rtl/vtc_regbank.sv
module vtc_regbank #(
   parameter int W     = 32,
   parameter int N     = 16,
   parameter int IDX_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx_a,
   output logic [W-1:0]     rdata_a,
   input  logic [IDX_W-1:0] ridx_b,
   output logic [W-1:0]     rdata_b
);
   logic [W-1:0] regs [N];

   for (genvar g = 0; g < N; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          regs[g] <= '0;
         else if (we && widx == IDX_W'(g))    regs[g] <= wdata;
      end
   end

   assign rdata_a = regs[ridx_a];
   assign rdata_b = regs[ridx_b];

endmodule

// File: rtl/vtc_stall.sv
module vtc_stall #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         first,
   input  logic [W-1:0] delay,
   input  logic [W-1:0] now,
   output logic         busy
);
   logic [W-1:0] start_q;
   logic [W-1:0] dly_q;
   logic [W-1:0] elapsed;

   assign elapsed = now - start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         dly_q   <= '0;
      end else if (active && first) begin
         start_q <= now;
         dly_q   <= delay;
      end
   end

   always_comb begin
      if (!active)     busy = 1'b0;
      else if (first)  busy = (delay != '0);
      else             busy = (elapsed < dly_q);
   end

endmodule

// File: rtl/vtc_alarm.sv
module vtc_alarm #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sched,
   input  logic         rel,
   input  logic [W-1:0] delay,
   input  logic [W-1:0] now,
   output logic         line_n
);
   logic         pend_q;
   logic [W-1:0] start_q;
   logic [W-1:0] dly_q;
   logic         expired;

   assign expired = pend_q && ((now - start_q) >= dly_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         line_n  <= 1'b1;
         start_q <= '0;
         dly_q   <= '0;
      end else if (rel) begin
         pend_q  <= 1'b0;
         line_n  <= 1'b1;
      end else if (sched) begin
         pend_q  <= 1'b1;
         start_q <= now;
         dly_q   <= delay;
      end else if (expired) begin
         pend_q  <= 1'b0;
         line_n  <= 1'b0;
      end
   end

endmodule

// File: rtl/valtest_cop.sv
module valtest_cop
   import vtc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 16,
   parameter int CP_A      = 4,
   parameter int CP_B      = 5,
   parameter bit LONG_PAIR = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cycle_now,
   input  logic              ins_valid,
   input  logic              ins_first,
   input  logic [2:0]        ins_kind,
   input  logic [3:0]        ins_cpnum,
   input  logic [31:0]       ins_word,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rsp,
   output logic              fiq_n,
   output logic              irq_n
);
   localparam int IDX_W  = $clog2(NUM_REGS);
   localparam int N_LINE = 2;

   if ((1 << IDX_W) != NUM_REGS || NUM_REGS < 2 || NUM_REGS > 16) begin : g_bad_regs
      $error("NUM_REGS must be a power of two from 2 to 16");
   end
   if (CP_A == CP_B || CP_A < 0 || CP_A > 15 || CP_B < 0 || CP_B > 15) begin : g_bad_cp
      $error("CP_A and CP_B must be distinct numbers below 16");
   end
   if (DATA_W < 4) begin : g_bad_w
      $error("DATA_W must be at least 4");
   end

   vtc_op_e          op;
   vtc_rsp_e         rsp_e;
   logic [IDX_W-1:0] rn_idx, rd_idx, rm_idx, xfer_idx, wr_idx, rda_idx;
   logic             is_long;
   logic             we;
   logic [DATA_W-1:0] wr_val, rda_val, delay_val;
   logic             stall_busy;
   logic [N_LINE-1:0] sched, rel, line_n;

   vtc_decode #(.CP_A(CP_A), .CP_B(CP_B), .IDX_W(IDX_W)) u_dec (
      .valid   (ins_valid),
      .kind    (ins_kind),
      .cpnum   (ins_cpnum),
      .word    (ins_word),
      .op      (op),
      .rn_idx  (rn_idx),
      .rd_idx  (rd_idx),
      .rm_idx  (rm_idx),
      .is_long (is_long)
   );

   if (LONG_PAIR) begin : g_pair
      assign xfer_idx = ins_first ? rd_idx : rd_idx + IDX_W'(1);
   end else begin : g_same
      assign xfer_idx = rd_idx;
   end

   always_comb begin
      we     = 1'b0;
      wr_idx = rn_idx;
      wr_val = wr_data;
      unique case (op)
         OP_WR:  we = 1'b1;
         OP_LD:  begin we = 1'b1; wr_idx = xfer_idx; end
         OP_CAP: begin we = 1'b1; wr_idx = rm_idx; wr_val = cycle_now; end
         default: ;
      endcase
   end

   assign rda_idx = (op == OP_ST) ? xfer_idx : rn_idx;

   vtc_regbank #(.W(DATA_W), .N(NUM_REGS), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .widx    (wr_idx),
      .wdata   (wr_val),
      .ridx_a  (rda_idx),
      .rdata_a (rda_val),
      .ridx_b  (rm_idx),
      .rdata_b (delay_val)
   );

   vtc_stall #(.W(DATA_W)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (op == OP_STALL),
      .first  (ins_first),
      .delay  (delay_val),
      .now    (cycle_now),
      .busy   (stall_busy)
   );

   assign sched[0] = (op == OP_SCHED_F);
   assign sched[1] = (op == OP_SCHED_I);
   assign rel[0]   = (op == OP_REL_F);
   assign rel[1]   = (op == OP_REL_I);

   for (genvar t = 0; t < N_LINE; t++) begin : g_line
      vtc_alarm #(.W(DATA_W)) u_alarm (
         .clk    (clk),
         .rst_n  (rst_n),
         .sched  (sched[t]),
         .rel    (rel[t]),
         .delay  (delay_val),
         .now    (cycle_now),
         .line_n (line_n[t])
      );
   end

   assign fiq_n = line_n[0];
   assign irq_n = line_n[1];

   always_comb begin
      unique case (op)
         OP_NONE:      rsp_e = RSP_ABSENT;
         OP_UNDEF:     rsp_e = RSP_UNDEF;
         OP_STALL:     rsp_e = stall_busy ? RSP_BUSY : RSP_DONE;
         OP_LD, OP_ST: rsp_e = (is_long && ins_first) ? RSP_BUSY : RSP_DONE;
         default:      rsp_e = RSP_DONE;
      endcase
   end

   assign rsp     = rsp_e;
   assign rd_data = (op == OP_RD || op == OP_ST) ? rda_val : '0;

endmodule

// File: rtl/vtc_checker.sv
module vtc_checker
   import vtc_pkg::*;
#(
   parameter int CP_A = 4,
   parameter int CP_B = 5
)(
   input logic        clk,
   input logic        rst_n,
   input logic        ins_valid,
   input logic        ins_first,
   input logic [2:0]  ins_kind,
   input logic [3:0]  ins_cpnum,
   input logic [31:0] ins_word,
   input logic [1:0]  rsp,
   input logic        fiq_n,
   input logic        irq_n
);
   logic on_a, on_b;
   assign on_a = ins_valid && ins_cpnum == 4'(CP_A);
   assign on_b = ins_valid && ins_cpnum == 4'(CP_B);

   p_lines_high_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (fiq_n && irq_n));

   p_reg_read_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((on_a || on_b) && ins_kind == KIND_REG_RD) |-> rsp == RSP_DONE);

   p_long_first_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (on_a && ins_first && ins_word[22] && (ins_kind == KIND_MEM_LD || ins_kind == KIND_MEM_ST))
      |-> rsp == RSP_BUSY);

   p_fast_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (on_b && ins_kind == KIND_DATAOP && ins_word[23:20] == 4'd3) |=> fiq_n);

   p_norm_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (on_b && ins_kind == KIND_DATAOP && ins_word[23:20] == 4'd4) |=> irq_n);

   p_mem_on_b_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (on_b && (ins_kind == KIND_MEM_LD || ins_kind == KIND_MEM_ST)) |-> rsp == RSP_UNDEF);

   p_foreign_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(on_a || on_b) |-> rsp == RSP_ABSENT);

endmodule

bind valtest_cop vtc_checker #(.CP_A(CP_A), .CP_B(CP_B)) u_vtc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_valid (ins_valid),
   .ins_first (ins_first),
   .ins_kind  (ins_kind),
   .ins_cpnum (ins_cpnum),
   .ins_word  (ins_word),
   .rsp       (rsp),
   .fiq_n     (fiq_n),
   .irq_n     (irq_n)
);

// File: tb/valtest_cop_tb_top.sv
module valtest_cop_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cycle_now = '0;
   logic        ins_valid = 1'b0;
   logic        ins_first = 1'b1;
   logic [2:0]  ins_kind = '0;
   logic [3:0]  ins_cpnum = '0;
   logic [31:0] ins_word = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  rsp;
   logic        fiq_n, irq_n;

   always #2 clk = ~clk;

   valtest_cop dut_i (
      .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now),
      .ins_valid(ins_valid), .ins_first(ins_first), .ins_kind(ins_kind),
      .ins_cpnum(ins_cpnum), .ins_word(ins_word), .wr_data(wr_data),
      .rd_data(rd_data), .rsp(rsp), .fiq_n(fiq_n), .irq_n(irq_n)
   );

   int    checks = 0;
   int    fails  = 0;
   string cur_tag = "R1";
   bit    done_flag = 0;

   // behavioural reference state
   logic [31:0] m_reg [16];
   bit          m_fiq, m_irq, m_fp, m_ip;
   logic [31:0] m_fs, m_fd, m_is, m_id, m_ss, m_sd;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", cur_tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) m_reg[i] = '0;
         m_fiq = 1; m_irq = 1; m_fp = 0; m_ip = 0;
         m_fs = 0; m_fd = 0; m_is = 0; m_id = 0; m_ss = 0; m_sd = 0;
         chk("fiq_n in reset R1", {31'b0, fiq_n}, 32'd1);
         chk("irq_n in reset R1", {31'b0, irq_n}, 32'd1);
      end else begin
         int opc, rn, rd, rm, xi;
         bit mine, cpa;
         int e_rsp;
         logic [31:0] e_rd;
         bit wr_en; int wr_i; logic [31:0] wr_v;
         bit sf, si, rf, ri;
         opc  = int'(ins_word[23:20]);
         rn   = int'(ins_word[19:16]);
         rd   = int'(ins_word[15:12]);
         rm   = int'(ins_word[3:0]);
         xi   = ins_first ? rd : (rd + 1) % 16;
         mine = ins_valid && (ins_cpnum == 4'd4 || ins_cpnum == 4'd5);
         cpa  = ins_cpnum == 4'd4;
         e_rsp = 0; e_rd = 0;
         wr_en = 0; wr_i = 0; wr_v = 0;
         sf = 0; si = 0; rf = 0; ri = 0;
         if (mine) begin
            case (int'(ins_kind))
               0: begin e_rsp = 1; wr_en = 1; wr_i = rn; wr_v = wr_data; end
               1: begin e_rsp = 1; e_rd = m_reg[rn]; end
               2, 3: begin
                  if (!cpa) e_rsp = 3;
                  else begin
                     e_rsp = (ins_word[22] && ins_first) ? 2 : 1;
                     if (ins_kind == 3'd3) e_rd = m_reg[xi];
                     else begin wr_en = 1; wr_i = xi; wr_v = wr_data; end
                  end
               end
               4: begin
                  if (opc == 0) begin
                     if (ins_first) begin
                        e_rsp = (m_reg[rm] != 0) ? 2 : 1;
                        m_ss = cycle_now; m_sd = m_reg[rm];
                     end else begin
                        e_rsp = ((cycle_now - m_ss) < m_sd) ? 2 : 1;
                     end
                  end else if (cpa || opc > 5) e_rsp = 3;
                  else begin
                     e_rsp = 1;
                     case (opc)
                        1: sf = 1;
                        2: si = 1;
                        3: rf = 1;
                        4: ri = 1;
                        default: begin wr_en = 1; wr_i = rm; wr_v = cycle_now; end
                     endcase
                  end
               end
               default: e_rsp = 3;
            endcase
         end
         chk("rsp", {30'b0, rsp}, 32'(e_rsp));
         chk("rd_data", rd_data, e_rd);
         chk("fiq_n", {31'b0, fiq_n}, {31'b0, m_fiq});
         chk("irq_n", {31'b0, irq_n}, {31'b0, m_irq});
         // state for the coming edge
         if (rf) begin m_fiq = 1; m_fp = 0; end
         else if (sf) begin m_fp = 1; m_fs = cycle_now; m_fd = m_reg[rm]; end
         else if (m_fp && (cycle_now - m_fs) >= m_fd) begin m_fiq = 0; m_fp = 0; end
         if (ri) begin m_irq = 1; m_ip = 0; end
         else if (si) begin m_ip = 1; m_is = cycle_now; m_id = m_reg[rm]; end
         else if (m_ip && (cycle_now - m_is) >= m_id) begin m_irq = 0; m_ip = 0; end
         if (wr_en) m_reg[wr_i] = wr_v;
      end
   end

   task automatic drive(input bit v, input int k, input int cp, input logic [31:0] w,
                        input logic [31:0] d, input bit f);
      @(posedge clk); #1;
      cycle_now = cycle_now + 1;
      ins_valid = v; ins_kind = 3'(k); ins_cpnum = 4'(cp);
      ins_word = w; wr_data = d; ins_first = f;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1);
   endtask

   function automatic logic [31:0] wreg(input int r);
      return 32'(r) << 16;
   endfunction
   function automatic logic [31:0] wmem(input int r, input bit lng);
      return (32'(lng) << 22) | (32'(r) << 12);
   endfunction
   function automatic logic [31:0] wop(input int opc, input int r);
      return (32'(opc) << 20) | 32'(r);
   endfunction

   task automatic stall(input int cp, input int r, input int hold);
      drive(1, 4, cp, wop(0, r), 0, 1);
      for (int i = 0; i < hold; i++) drive(1, 4, cp, wop(0, r), 0, 0);
   endtask

   initial begin
      cur_tag = "R1";
      idle(4);
      rst_n = 1'b1;
      idle(2);
      for (int r = 0; r < 16; r++) drive(1, 1, 4, wreg(r), 0, 1);

      cur_tag = "R2";
      drive(1, 0, 4, wreg(3), 32'hA5A5_0F0F, 1);
      drive(1, 0, 5, wreg(9), 32'h1234_5678, 1);
      drive(1, 1, 5, wreg(3), 0, 1);
      drive(1, 1, 4, wreg(9), 0, 1);

      cur_tag = "R9";
      drive(1, 0, 7, wreg(3), 32'hDEAD_BEEF, 1);
      drive(0, 0, 4, wreg(3), 32'hDEAD_BEEF, 1);
      drive(1, 4, 6, wop(1, 0), 0, 1);
      drive(1, 1, 4, wreg(3), 0, 1);
      idle(3);

      cur_tag = "R3";
      drive(1, 2, 4, wmem(6, 0), 32'h0000_0066, 1);
      drive(1, 2, 4, wmem(15, 1), 32'hF0F0_000F, 1);
      drive(1, 2, 4, wmem(15, 1), 32'h0F0F_0000, 0);
      drive(1, 3, 4, wmem(15, 1), 0, 1);
      drive(1, 3, 4, wmem(15, 1), 0, 0);
      drive(1, 3, 4, wmem(6, 0), 0, 1);
      drive(1, 1, 5, wreg(0), 0, 1);

      cur_tag = "R8";
      drive(1, 2, 5, wmem(2, 0), 32'h7777_7777, 1);
      drive(1, 3, 5, wmem(2, 0), 0, 1);
      drive(1, 4, 4, wop(2, 1), 0, 1);
      drive(1, 4, 5, wop(7, 1), 0, 1);
      drive(1, 6, 4, wreg(2), 32'h5555_5555, 1);
      drive(1, 1, 4, wreg(2), 0, 1);
      idle(3);

      cur_tag = "R4";
      drive(1, 0, 4, wreg(1), 32'd5, 1);
      drive(1, 0, 4, wreg(4), 32'd0, 1);
      drive(1, 0, 4, wreg(5), 32'd3, 1);
      stall(4, 1, 8);
      stall(4, 4, 2);
      stall(5, 5, 6);
      idle(2);

      cur_tag = "R5";
      drive(1, 0, 5, wreg(2), 32'd4, 1);
      drive(1, 4, 5, wop(1, 2), 0, 1);
      idle(8);
      drive(1, 4, 5, wop(2, 4), 0, 1);
      idle(4);
      cur_tag = "R6";
      drive(1, 4, 5, wop(3, 0), 0, 1);
      drive(1, 4, 5, wop(4, 0), 0, 1);
      idle(2);
      drive(1, 0, 5, wreg(8), 32'd10, 1);
      drive(1, 4, 5, wop(1, 8), 0, 1);
      idle(3);
      drive(1, 4, 5, wop(3, 0), 0, 1);
      idle(14);
      drive(1, 4, 5, wop(2, 2), 0, 1);
      idle(3);
      drive(1, 4, 5, wop(4, 0), 0, 1);
      idle(6);

      cur_tag = "R7";
      drive(1, 4, 5, wop(5, 7), 0, 1);
      drive(1, 1, 4, wreg(7), 0, 1);
      idle(2);

      cur_tag = "R10";
      cycle_now = 32'hFFFF_FFF0;
      drive(1, 0, 4, wreg(1), 32'd40, 1);
      drive(1, 0, 4, wreg(2), 32'd30, 1);
      stall(4, 1, 44);
      cycle_now = 32'hFFFF_FFF4;
      drive(1, 4, 5, wop(2, 2), 0, 1);
      idle(34);
      drive(1, 4, 5, wop(4, 0), 0, 1);
      cycle_now = 32'hFFFF_FFFD;
      drive(1, 4, 5, wop(5, 11), 0, 1);
      drive(1, 1, 5, wreg(11), 0, 1);
      idle(4);

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule